// File: doc/BRIEF.md
# Set-Tagged Streaming Reduction Controller

This block sums groups of integer values that arrive one per clock cycle. Every value carries a set identifier. Consecutive values with the same identifier belong to one set, and the block emits one total per set. The totals leave in the order the sets arrived. Input is taken every cycle with no backpressure. A single adder is shared by all sets. The adder is an ideal integer pipeline with a three-cycle latency, so up to three partial sums of one set are in flight at the same time.

There is no partial-sum memory. A phase counter restarts whenever a new set begins, and for the first eight cycles of each set it steps through a fixed schedule of four operand routings:

- the new value against zero;
- a parked partial against the pipeline output;
- a held input against the new value;
- the pipeline output against the new value.

During those eight cycles the three leftover partials of the previous set are folded into its total. A one-entry output-side buffer parks partials of the old set, and a one-entry input-side buffer holds values of the new set. From the ninth cycle onward, each new value is simply added to the partial leaving the pipeline. For this reason every set must span at least eight cycles.

A total cannot be known before the set has ended. The total of the newest set therefore leaves only after the next set has started.

Top module: `setsum_reducer`

## Requirements
- R1: Each emitted `out_sum` equals the sum, modulo 2^DATA_W, of all values sampled while that set was open, and `out_set_id` carries the identifier of the set's first value.
- R2: Exactly one total is emitted per closed set, and totals leave in the same order in which their sets started.
- R3: A set's total is presented with `out_valid` high right after the sixth rising edge that follows the edge sampling the first value of the next set.
- R4: A cycle with `in_valid` low while a set is open adds zero to that set, counts toward its span and does not close it.
- R5: A set closes only when a valid value with a different identifier arrives; the total of the most recent set is held back until then.
- R6: If a valid value with a different identifier arrives before the open set has spanned 8 cycles, then:
  - `short_set` is high in the cycle after that value is sampled;
  - the value and the values that follow it are merged into the open set;
  - the merged total is emitted with the first set's identifier and `out_bad` high;
  - `out_bad` is never high without `out_valid`.
- R7: `out_valid` is a single-cycle pulse, and two totals are never closer than 8 cycles apart.
- R8: After reset, `out_valid`, `out_bad` and `short_set` are low and `out_sum` is zero.
- R9: Idle cycles after reset, before the first valid value, produce no total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Value present this cycle |
| in_data | input | DATA_W | Value to accumulate |
| in_set_id | input | ID_W | Set identifier of the value |
| out_valid | output | 1 | Total present this cycle |
| out_sum | output | DATA_W | Set total, meaningful when out_valid is high |
| out_set_id | output | ID_W | Identifier of the set whose total is shown |
| out_bad | output | 1 | Total belongs to a set that was too short and was merged |
| short_set | output | 1 | Pulse: a set change arrived before the minimum span |

## Verification
The bench builds the block with DATA_W = 32, ID_W = 8, LAT = 3 and the early-sum pipeline variant. With these values the phase schedule has exactly eight steps, and values near 2^32 make wrap-around of the sum reachable. Identifiers are drawn at random from the full 8-bit range, so a new set may reuse an identifier seen earlier, provided it differs from the one just before it.

The stream mixes several kinds of sets:
- back-to-back sets of exactly the minimum span;
- sets with idle holes;
- chains of short sets that merge;
- random sets of 8 to 30 cycles.

The emission cycle of every total is predicted from the start of the following set.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

   // operand routing presented to the shared adder
   typedef enum logic [1:0] {
      RT_SEED = 2'd0,   // new value + zero
      RT_FOLD = 2'd1,   // parked partial + pipeline output
      RT_PAIR = 2'd2,   // held input + new value
      RT_RUN  = 2'd3    // pipeline output + new value
   } route_e;

   // phase on which the previous set's last fold enters the adder
   localparam int FINAL_PH = 5;

   function automatic int min_span(int lat);
      return 3 * lat - 1;
   endfunction

   function automatic route_e route_at(int ph);
      case (ph)
         1:       return RT_SEED;
         2, 5:    return RT_FOLD;
         3, 8:    return RT_PAIR;
         default: return RT_RUN;
      endcase
   endfunction

   // output-side buffer captures the pipeline output
   function automatic logic park_pipe(int ph);
      return (ph == 1) || (ph == 3);
   endfunction

   // input-side buffer captures the incoming value
   function automatic logic park_input(int ph);
      return (ph == 2) || (ph == 5);
   endfunction

endpackage

// File: rtl/ssr_seq.sv
module ssr_seq
   import ssr_pkg::*;
#(
   parameter int ID_W = 8,
   parameter int LAT  = 3,
   parameter int PH_W = 4
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [ID_W-1:0] in_set_id,
   output logic [PH_W-1:0] phase_o,
   output logic            final_o,
   output logic [ID_W-1:0] fin_id_o,
   output logic            fin_bad_o,
   output logic            fin_real_o,
   output logic            short_o
);

   localparam int MIN_SET = min_span(LAT);
   localparam int PH_SAT  = MIN_SET + 1;
   localparam logic [PH_W-1:0] SAT_V = PH_W'(PH_SAT);
   localparam logic [PH_W-1:0] MIN_V = PH_W'(MIN_SET);

   logic [PH_W-1:0] ph_q, ph_now;
   logic            open_q;
   logic [ID_W-1:0] grp_id_q, tot_id_q, prev_id_q;
   logic            bad_q, prev_bad_q, prev_real_q, short_q;
   logic            differs, start, merge;

   always_comb begin
      differs = in_valid && (!open_q || (in_set_id != grp_id_q));
      start   = differs && (!open_q || (ph_q >= MIN_V));
      merge   = differs && !start;
      if (start)
         ph_now = PH_W'(1);
      else if (ph_q == SAT_V)
         ph_now = SAT_V;
      else
         ph_now = ph_q + PH_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q        <= SAT_V;
         open_q      <= 1'b0;
         grp_id_q    <= '0;
         tot_id_q    <= '0;
         bad_q       <= 1'b0;
         prev_id_q   <= '0;
         prev_bad_q  <= 1'b0;
         prev_real_q <= 1'b0;
         short_q     <= 1'b0;
      end else begin
         ph_q    <= ph_now;
         short_q <= merge;
         if (start) begin
            open_q      <= 1'b1;
            grp_id_q    <= in_set_id;
            tot_id_q    <= in_set_id;
            bad_q       <= 1'b0;
            prev_id_q   <= tot_id_q;
            prev_bad_q  <= bad_q;
            prev_real_q <= open_q;
         end else if (merge) begin
            grp_id_q <= in_set_id;
            bad_q    <= 1'b1;
         end
      end
   end

   assign phase_o    = ph_now;
   assign final_o    = (ph_now == PH_W'(FINAL_PH));
   assign fin_id_o   = prev_id_q;
   assign fin_bad_o  = prev_bad_q;
   assign fin_real_o = prev_real_q;
   assign short_o    = short_q;

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(grp_id_q));

endmodule

// File: rtl/ssr_route.sv
module ssr_route
   import ssr_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int PH_W       = 4,
   parameter bit RESET_BUFS = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [DATA_W-1:0] pipe_sum,
   input  logic [PH_W-1:0]   phase,
   output logic [DATA_W-1:0] op_a,
   output logic [DATA_W-1:0] op_b
);

   logic [DATA_W-1:0] x;
   logic [DATA_W-1:0] obuf_q, ibuf_q;
   logic              take_pipe, take_in;

   assign x         = in_valid ? in_data : '0;
   assign take_pipe = park_pipe(int'(phase));
   assign take_in   = park_input(int'(phase));

   always_comb begin
      case (route_at(int'(phase)))
         RT_SEED: begin op_a = x;      op_b = '0;       end
         RT_FOLD: begin op_a = obuf_q; op_b = pipe_sum; end
         RT_PAIR: begin op_a = ibuf_q; op_b = x;        end
         default: begin op_a = pipe_sum; op_b = x;      end
      endcase
   end

   generate
      if (RESET_BUFS) begin : g_rst_bufs
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               obuf_q <= '0;
               ibuf_q <= '0;
            end else begin
               if (take_pipe) obuf_q <= pipe_sum;
               if (take_in)   ibuf_q <= x;
            end
         end
      end else begin : g_free_bufs
         always_ff @(posedge clk) begin
            if (take_pipe) obuf_q <= pipe_sum;
            if (take_in)   ibuf_q <= x;
         end
      end
   endgenerate

endmodule

// File: rtl/ssr_pipe.sv
module ssr_pipe #(
   parameter int DATA_W   = 32,
   parameter int ID_W     = 8,
   parameter int LAT      = 3,
   parameter bit SUM_LATE = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              emit_i,
   input  logic              bad_i,
   input  logic [ID_W-1:0]   id_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              emit_o,
   output logic              bad_o,
   output logic [ID_W-1:0]   id_o
);

   logic [LAT-1:0]  emit_q, bad_q;
   logic [ID_W-1:0] id_q [LAT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         emit_q <= '0;
         bad_q  <= '0;
         for (int i = 0; i < LAT; i++) id_q[i] <= '0;
      end else begin
         emit_q <= {emit_q[LAT-2:0], emit_i};
         bad_q  <= {bad_q[LAT-2:0], bad_i};
         id_q[0] <= id_i;
         for (int i = 1; i < LAT; i++) id_q[i] <= id_q[i-1];
      end
   end

   generate
      if (!SUM_LATE) begin : g_early
         logic [DATA_W-1:0] s_q [LAT];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < LAT; i++) s_q[i] <= '0;
            end else begin
               s_q[0] <= a_i + b_i;
               for (int i = 1; i < LAT; i++) s_q[i] <= s_q[i-1];
            end
         end
         assign sum_o = s_q[LAT-1];
      end else begin : g_late
         logic [DATA_W-1:0] a_q [LAT];
         logic [DATA_W-1:0] b_q [LAT];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < LAT; i++) begin
                  a_q[i] <= '0;
                  b_q[i] <= '0;
               end
            end else begin
               a_q[0] <= a_i;
               b_q[0] <= b_i;
               for (int i = 1; i < LAT; i++) begin
                  a_q[i] <= a_q[i-1];
                  b_q[i] <= b_q[i-1];
               end
            end
         end
         assign sum_o = a_q[LAT-1] + b_q[LAT-1];
      end
   endgenerate

   assign emit_o = emit_q[LAT-1];
   assign bad_o  = bad_q[LAT-1];
   assign id_o   = id_q[LAT-1];

endmodule

// File: rtl/setsum_reducer.sv
module setsum_reducer
   import ssr_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ID_W       = 8,
   parameter int LAT        = 3,
   parameter bit SUM_LATE   = 1'b0,
   parameter bit RESET_BUFS = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [ID_W-1:0]   in_set_id,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_sum,
   output logic [ID_W-1:0]   out_set_id,
   output logic              out_bad,
   output logic              short_set
);

   localparam int MIN_SET = min_span(LAT);
   localparam int PH_W    = $clog2(MIN_SET + 2);
   localparam int EMIT_PH = FINAL_PH + LAT;

   generate
      if (LAT != 3) begin : g_lat_chk
         $error("setsum_reducer: routing schedule is built for LAT of 3");
      end
      if (DATA_W < 2) begin : g_dw_chk
         $error("setsum_reducer: DATA_W must be at least 2");
      end
      if (ID_W < 1) begin : g_id_chk
         $error("setsum_reducer: ID_W must be at least 1");
      end
   endgenerate

   logic [PH_W-1:0]   phase;
   logic              fin_go, fin_bad, fin_real;
   logic [ID_W-1:0]   fin_id;
   logic [DATA_W-1:0] op_a, op_b, pipe_sum;
   logic              tag_emit, tag_bad;

   ssr_seq #(.ID_W(ID_W), .LAT(LAT), .PH_W(PH_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_set_id  (in_set_id),
      .phase_o    (phase),
      .final_o    (fin_go),
      .fin_id_o   (fin_id),
      .fin_bad_o  (fin_bad),
      .fin_real_o (fin_real),
      .short_o    (short_set)
   );

   ssr_route #(.DATA_W(DATA_W), .PH_W(PH_W), .RESET_BUFS(RESET_BUFS)) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .pipe_sum (pipe_sum),
      .phase    (phase),
      .op_a     (op_a),
      .op_b     (op_b)
   );

   assign tag_emit = fin_go & fin_real;
   assign tag_bad  = tag_emit & fin_bad;

   ssr_pipe #(.DATA_W(DATA_W), .ID_W(ID_W), .LAT(LAT), .SUM_LATE(SUM_LATE)) u_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_i    (op_a),
      .b_i    (op_b),
      .emit_i (tag_emit),
      .bad_i  (tag_bad),
      .id_i   (fin_id),
      .sum_o  (pipe_sum),
      .emit_o (out_valid),
      .bad_o  (out_bad),
      .id_o   (out_set_id)
   );

   assign out_sum = pipe_sum;

   // spacing monitor for consecutive totals
   logic [PH_W-1:0] gap_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         gap_q <= PH_W'(MIN_SET);
      else if (out_valid)
         gap_q <= '0;
      else if (gap_q < PH_W'(MIN_SET))
         gap_q <= gap_q + PH_W'(1);
   end

   // R7
   emit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (gap_q >= PH_W'(MIN_SET - 1)));

   // R3
   emit_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (phase == PH_W'(EMIT_PH)));

   // R6
   bad_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_bad |-> out_valid);

endmodule

// File: tb/setsum_reducer_tb.sv
module setsum_reducer_tb;

   localparam int DW   = 32;
   localparam int IW   = 8;
   localparam int MAXC = 2400;
   localparam int MAXE = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic [IW-1:0] in_set_id = '0;
   logic          out_valid, out_bad, short_set;
   logic [DW-1:0] out_sum;
   logic [IW-1:0] out_set_id;

   always #5 clk = ~clk;

   setsum_reducer #(.DATA_W(DW), .ID_W(IW), .LAT(3), .SUM_LATE(1'b0), .RESET_BUFS(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_set_id(in_set_id), .out_valid(out_valid), .out_sum(out_sum),
      .out_set_id(out_set_id), .out_bad(out_bad), .short_set(short_set)
   );

   // stimulus stream
   logic          st_v  [MAXC];
   logic [IW-1:0] st_id [MAXC];
   logic [DW-1:0] st_d  [MAXC];
   string         st_req[MAXC];
   int            n_st = 0;

   // expected results
   logic [IW-1:0] e_id  [MAXE];
   logic [DW-1:0] e_sum [MAXE];
   logic          e_bad [MAXE];
   int            e_nidx[MAXE];
   string         e_req [MAXE];
   int            n_exp = 0;
   int            m_idx [64];
   int            n_mrg = 0;

   int checks = 0, errors = 0;
   int edge_cnt = 0, base_edge = 0;
   int n_got = 0, n_sh = 0, n_early = 0;
   bit mon_on = 1'b0, done = 1'b0, prev_ov = 1'b0;
   logic [IW-1:0] last_id = '0;

   always @(posedge clk) edge_cnt++;

   task automatic check(bit ok, string req, string what, longint act, longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic put(bit v, logic [IW-1:0] id, logic [DW-1:0] d, string req);
      if (n_st < MAXC) begin
         st_v[n_st] = v; st_id[n_st] = id; st_d[n_st] = d; st_req[n_st] = req;
         n_st++;
      end
   endtask

   task automatic put_set(logic [IW-1:0] id, int len, int hole_mod, string req);
      for (int k = 0; k < len; k++) begin
         if (k > 0 && hole_mod > 0 && ($urandom % hole_mod) == 0)
            put(1'b0, $urandom, $urandom, req);
         else
            put(1'b1, id, $urandom, req);
      end
      last_id = id;
   endtask

   function automatic void build_model();
      bit            open = 1'b0;
      bit            bad = 1'b0;
      logic [IW-1:0] gid = '0, tid = '0;
      logic [DW-1:0] sum = '0;
      int            cnt = 0;
      string         req = "R1";
      for (int i = 0; i < n_st; i++) begin
         if (st_v[i]) begin
            if (!open || st_id[i] != gid) begin
               if (!open || cnt >= 8) begin
                  if (open && n_exp < MAXE) begin
                     e_id[n_exp] = tid; e_sum[n_exp] = sum; e_bad[n_exp] = bad;
                     e_nidx[n_exp] = i; e_req[n_exp] = req;
                     n_exp++;
                  end
                  open = 1'b1; gid = st_id[i]; tid = st_id[i];
                  sum = st_d[i]; cnt = 1; bad = 1'b0; req = st_req[i];
               end else begin
                  bad = 1'b1; gid = st_id[i]; sum = sum + st_d[i]; cnt++;
                  if (n_mrg < 64) begin m_idx[n_mrg] = i; n_mrg++; end
               end
            end else begin
               sum = sum + st_d[i]; cnt++;
            end
         end else if (open) begin
            cnt++;
         end
      end
   endfunction

   // output monitor
   always @(negedge clk) begin
      if (mon_on) begin
         if (out_valid) begin
            check(!prev_ov, "R7", "out_valid held longer than one cycle", 1, 0);
            if (edge_cnt < base_edge + 12 + 7) n_early++;
            if (n_got < n_exp) begin
               check(out_sum == e_sum[n_got], e_req[n_got], "total value", out_sum, e_sum[n_got]);
               check(out_set_id == e_id[n_got], "R2", "total order/id", out_set_id, e_id[n_got]);
               check(out_bad == e_bad[n_got], "R6", "invalid mark", out_bad, e_bad[n_got]);
               check(edge_cnt == base_edge + e_nidx[n_got] + 6, "R3", "emit cycle",
                     edge_cnt, base_edge + e_nidx[n_got] + 6);
            end else begin
               check(1'b0, "R2", "total beyond expected count", n_got, n_exp);
            end
            n_got++;
         end
         if (short_set) begin
            if (n_sh < n_mrg)
               check(edge_cnt == base_edge + m_idx[n_sh], "R6", "short_set cycle",
                     edge_cnt, base_edge + m_idx[n_sh]);
            else
               check(1'b0, "R6", "unexpected short_set", n_sh, n_mrg);
            n_sh++;
         end
         prev_ov = out_valid;
      end
   end

   initial begin
      void'($urandom(32'd20240611));

      // R9: idle before the first set
      for (int k = 0; k < 12; k++) put(1'b0, 8'h00, 32'h0, "R9");
      // minimum-span sets back to back
      for (int k = 1; k <= 8; k++) put(1'b1, 8'h05, DW'(k), "R1");
      for (int k = 1; k <= 8; k++) put(1'b1, 8'h06, DW'(100 * k), "R1");
      // R4: holes inside a set
      for (int k = 0; k < 9; k++)
         put((k != 3 && k != 6), 8'h07, 32'h1000 + DW'(k), "R4");
      for (int k = 1; k <= 8; k++) put(1'b1, 8'h05, DW'(7 * k), "R1");
      // wrap-around values
      for (int k = 0; k < 8; k++) put(1'b1, 8'h09, 32'hFFFF_FFF0 + DW'(k), "R1");
      // R6: short set merged with the next one
      for (int k = 0; k < 4; k++) put(1'b1, 8'h03, DW'(11 + k), "R6");
      for (int k = 0; k < 10; k++) put(1'b1, 8'h04, DW'(50 + k), "R6");
      // R6: chain of short sets
      for (int k = 0; k < 2; k++) put(1'b1, 8'h12, DW'(3 + k), "R6");
      for (int k = 0; k < 2; k++) put(1'b1, 8'h13, DW'(30 + k), "R6");
      for (int k = 0; k < 8; k++) put(1'b1, 8'h14, DW'(300 + k), "R6");
      put_set(8'h20, 8, 0, "R1");
      // random sets
      for (int s = 0; s < 60; s++) begin
         logic [IW-1:0] nid;
         int len;
         nid = IW'($urandom);
         if (nid == last_id) nid = nid + 8'd1;
         len = 8 + int'($urandom % 23);
         if (n_st + len < MAXC - 40) put_set(nid, len, 8, "R1");
      end
      // R5: closing set whose own total stays held back
      put_set(last_id + 8'd1, 8, 0, "R5");

      build_model();

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8
      check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
      check(out_bad == 1'b0, "R8", "out_bad after reset", out_bad, 0);
      check(short_set == 1'b0, "R8", "short_set after reset", short_set, 0);
      check(out_sum == '0, "R8", "out_sum after reset", out_sum, 0);

      base_edge = edge_cnt + 1;
      mon_on = 1'b1;
      for (int i = 0; i < n_st; i++) begin
         in_valid  = st_v[i];
         in_set_id = st_id[i];
         in_data   = st_d[i];
         @(negedge clk);
      end
      in_valid = 1'b0;
      in_data  = '0;
      repeat (30) @(negedge clk);

      check(n_early == 0, "R9", "total before first set could close", n_early, 0);
      check(n_got == n_exp, "R5", "number of totals (newest set held)", n_got, n_exp);
      check(n_sh == n_mrg, "R6", "number of short_set pulses", n_sh, n_mrg);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog expired actual=%0d expected=%0d", n_got, n_exp);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule